// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block sits between a board's expansion bus and the processor's interrupt input. An interrupt event arrives as a strobe together with the number of the slot that raised it and the pin it used, where pins A through D are coded 0 to 3. A fixed board table turns that pair into an interrupt number. Numbers from 32 upward belong to the router's own bank of 32 local interrupts.

For a local interrupt, the router reads two 32-bit configuration words, one for edge mode and one for polarity. Both are indexed by the local index, which is the interrupt number minus 32. If the edge bit is set, the processor line gives a single-cycle pulse. If the edge bit is clear, the line is driven to the level held in the polarity bit and stays there. Numbers that are not local leave the line alone.

The mapped number is shown on an output at all times, so the routing can be observed whether or not an event is present. The processor line is a register.

Top module: `irq_slot_router`

## Requirements
- R1: Slot 5 maps to 32 plus the pin number taken modulo 4.
- R2: Slot 6 maps to 36 and slot 7 maps to 37, whatever the pin.
- R3: Slots 8 to 12 map to (slot − 8 + pin) + 38.
- R4: Any other slot (0–4, 13–31) maps to the pin number unchanged. This value is below 32, so it is not local.
- R5: While reset is low, and in the first cycle after it, `cpu_irq` is 0.
- R6: An accepted event with the edge bit of its local index set raises `cpu_irq` in the next cycle. If no accepted event follows in the next cycle, the line drops to 0 again.
- R7: An accepted event with the edge bit clear and the polarity bit set drives `cpu_irq` to 1 in the next cycle.
- R8: An accepted event with the edge bit clear and the polarity bit clear drives `cpu_irq` to 0 in the next cycle.
- R9: An event whose mapped number lies outside 32–63 is not accepted. It does not change a held level, and a pulse that is still running ends as normal.
- R10: When an accepted event falls in the last cycle of a pulse, that event decides the next line value. The pulse does not.
- R11: With no strobe, a held level stays put. Changes to `edge_cfg` or `pol_cfg` alone do not move the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | Interrupt event strobe, one per cycle |
| evt_slot | input | 5 | Slot number of the requesting device |
| evt_pin | input | 2 | Interrupt pin, A=0 to D=3 |
| edge_cfg | input | 32 | Per-local-interrupt edge mode bits (1 = pulse) |
| pol_cfg | input | 32 | Per-local-interrupt level bits used in level mode |
| irq_num | output | 8 | Mapped interrupt number for the current slot and pin |
| cpu_irq | output | 1 | Registered interrupt line to the processor |

## Verification
Two functions can land in the same cycle: the automatic end of an edge pulse, and the acceptance of a new event. The bench provokes this with strobes on consecutive cycles. It pairs an edge event with a second edge event, with a level event of either polarity, and with a non-local event. In each case it checks that the new event decides the line and that the pulse ends only when nothing is accepted. A long pseudo-random run mixes these pairings with changes to the configuration words. Every cycle is compared against an arithmetic model of the line.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int unsigned SLOT_W   = 5;
  localparam int unsigned PIN_W    = 2;
  localparam int unsigned NUM_W    = 8;
  localparam int unsigned LOCAL_W  = 5;
  localparam int unsigned LOCAL_N  = 1 << LOCAL_W;
  localparam int unsigned IRQ_BASE = 32;

  typedef logic [SLOT_W-1:0]  slot_t;
  typedef logic [PIN_W-1:0]   pin_t;
  typedef logic [NUM_W-1:0]   irq_num_t;
  typedef logic [LOCAL_W-1:0] local_idx_t;
  typedef logic [LOCAL_N-1:0] cfg_word_t;

  // Line action chosen for an accepted local event
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_PULSE = 2'd1,
    ACT_HIGH  = 2'd2,
    ACT_LOW   = 2'd3
  } line_act_e;
endpackage

// File: rtl/irq_slot_map.sv
`timescale 1ns/1ps
module irq_slot_map
  import irq_route_pkg::*;
#(
  parameter int unsigned HUB_SLOT  = 5,
  parameter int unsigned GFX_SLOT  = 6,
  parameter int unsigned GFX_LOCAL = 4,
  parameter int unsigned NIC_SLOT  = 7,
  parameter int unsigned NIC_LOCAL = 5,
  parameter int unsigned EXP_FIRST = 8,
  parameter int unsigned EXP_LAST  = 12,
  parameter int unsigned EXP_LOCAL = 6
) (
  input  slot_t      slot,
  input  pin_t       pin,
  output irq_num_t   num,
  output logic       is_local,
  output local_idx_t local_idx
);
  localparam slot_t    S_HUB  = slot_t'(HUB_SLOT);
  localparam slot_t    S_GFX  = slot_t'(GFX_SLOT);
  localparam slot_t    S_NIC  = slot_t'(NIC_SLOT);
  localparam slot_t    S_EXP0 = slot_t'(EXP_FIRST);
  localparam slot_t    S_EXP1 = slot_t'(EXP_LAST);
  localparam irq_num_t N_LO   = irq_num_t'(IRQ_BASE);
  localparam irq_num_t N_HI   = irq_num_t'(IRQ_BASE + LOCAL_N - 1);

  function automatic irq_num_t route(input slot_t s, input pin_t p);
    irq_num_t r;
    if (s == S_HUB)
      r = N_LO + irq_num_t'(p[1:0]);                 // pin modulo 4
    else if (s == S_GFX)
      r = N_LO + irq_num_t'(GFX_LOCAL);
    else if (s == S_NIC)
      r = N_LO + irq_num_t'(NIC_LOCAL);
    else if (s >= S_EXP0 && s <= S_EXP1)
      r = N_LO + irq_num_t'(EXP_LOCAL) + (irq_num_t'(s) - irq_num_t'(S_EXP0))
          + irq_num_t'(p);
    else
      r = irq_num_t'(p);                             // passthrough
    return r;
  endfunction

  function automatic logic in_bank(input irq_num_t n);
    return (n >= N_LO) && (n <= N_HI);
  endfunction

  always_comb begin
    num       = route(slot, pin);
    is_local  = in_bank(num);
    local_idx = local_idx_t'(num - N_LO);
  end
endmodule

// File: rtl/irq_line_drv.sv
`timescale 1ns/1ps
module irq_line_drv
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       is_local,
  input  local_idx_t local_idx,
  input  cfg_word_t  edge_cfg,
  input  cfg_word_t  pol_cfg,
  output logic       accept,
  output logic       sel_edge,
  output logic       sel_pol,
  output logic       pulse_active,
  output logic       line
);
  line_act_e act;

  function automatic line_act_e pick(input logic acc, input logic e, input logic p);
    if (!acc)  return ACT_NONE;
    if (e)     return ACT_PULSE;
    return p ? ACT_HIGH : ACT_LOW;
  endfunction

  always_comb begin
    accept   = fire & is_local;
    sel_edge = edge_cfg[local_idx];
    sel_pol  = pol_cfg[local_idx];
    act      = pick(accept, sel_edge, sel_pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line         <= 1'b0;
      pulse_active <= 1'b0;
    end else begin
      unique case (act)
        ACT_PULSE: begin line <= 1'b1; pulse_active <= 1'b1; end
        ACT_HIGH:  begin line <= 1'b1; pulse_active <= 1'b0; end
        ACT_LOW:   begin line <= 1'b0; pulse_active <= 1'b0; end
        default: begin
          if (pulse_active) begin
            line         <= 1'b0;
            pulse_active <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_slot_router.sv
`timescale 1ns/1ps
module irq_slot_router
  import irq_route_pkg::*;
#(
  parameter int unsigned HUB_SLOT  = 5,
  parameter int unsigned GFX_SLOT  = 6,
  parameter int unsigned GFX_LOCAL = 4,
  parameter int unsigned NIC_SLOT  = 7,
  parameter int unsigned NIC_LOCAL = 5,
  parameter int unsigned EXP_FIRST = 8,
  parameter int unsigned EXP_LAST  = 12,
  parameter int unsigned EXP_LOCAL = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [SLOT_W-1:0]   evt_slot,
  input  logic [PIN_W-1:0]    evt_pin,
  input  logic [LOCAL_N-1:0]  edge_cfg,
  input  logic [LOCAL_N-1:0]  pol_cfg,
  output logic [NUM_W-1:0]    irq_num,
  output logic                cpu_irq
);
  // Named internal events, visible to the bound checker
  logic       evt_local;
  local_idx_t evt_idx;
  logic       evt_accept;
  logic       sel_edge;
  logic       sel_pol;
  logic       pulse_active;

  irq_slot_map #(
    .HUB_SLOT(HUB_SLOT), .GFX_SLOT(GFX_SLOT), .GFX_LOCAL(GFX_LOCAL),
    .NIC_SLOT(NIC_SLOT), .NIC_LOCAL(NIC_LOCAL),
    .EXP_FIRST(EXP_FIRST), .EXP_LAST(EXP_LAST), .EXP_LOCAL(EXP_LOCAL)
  ) u_map (
    .slot      (evt_slot),
    .pin       (evt_pin),
    .num       (irq_num),
    .is_local  (evt_local),
    .local_idx (evt_idx)
  );

  irq_line_drv u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (evt_valid),
    .is_local     (evt_local),
    .local_idx    (evt_idx),
    .edge_cfg     (edge_cfg),
    .pol_cfg      (pol_cfg),
    .accept       (evt_accept),
    .sel_edge     (sel_edge),
    .sel_pol      (sel_pol),
    .pulse_active (pulse_active),
    .line         (cpu_irq)
  );
endmodule

// File: rtl/irq_slot_router_chk.sv
`timescale 1ns/1ps
module irq_slot_router_chk
  import irq_route_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [LOCAL_N-1:0] edge_cfg,
  input logic [LOCAL_N-1:0] pol_cfg,
  input logic               evt_local,
  input local_idx_t         evt_idx,
  input logic               evt_accept,
  input logic               pulse_active,
  input logic               cpu_irq
);
  assert_reset_low_R5: assert property (@(posedge clk)
    !rst_n |=> !cpu_irq);

  assert_edge_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_local && edge_cfg[evt_idx]) |=> (cpu_irq && pulse_active));

  assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && !evt_accept) |=> (!cpu_irq && !pulse_active));

  assert_level_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_local && !edge_cfg[evt_idx] && pol_cfg[evt_idx]) |=> cpu_irq);

  assert_level_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_local && !edge_cfg[evt_idx] && !pol_cfg[evt_idx]) |=> !cpu_irq);

  assert_foreign_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_local && !pulse_active) |=> $stable(cpu_irq));

  assert_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && evt_accept && !edge_cfg[evt_idx]) |=> !pulse_active);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !pulse_active) |=> $stable(cpu_irq));
endmodule

bind irq_slot_router irq_slot_router_chk u_chk (.*);

// File: tb/test_irq_slot_router.sv
`timescale 1ns/1ps
module test_irq_slot_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic [7:0]  irq_num;
  logic        cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] cur_edge = '0;
  logic [31:0] cur_pol = '0;
  logic exp_line = 1'b0;
  logic exp_pulse = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  irq_slot_router i_irq_slot_router (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_pin(evt_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
    .irq_num(irq_num), .cpu_irq(cpu_irq));

  function automatic int exp_num(input int s, input int p);
    if (s == 5) return 32 + p;
    if (s == 6 || s == 7) return s + 30;
    if (s >= 8 && s <= 12) return s + p + 30;
    return p;
  endfunction

  task automatic check(input int act, input int expv, input string tag);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic model(input logic v, input int s, input int p);
    int n;
    n = exp_num(s, p);
    if (v && n >= 32 && n <= 63) begin
      if (cur_edge[n-32]) begin exp_line = 1'b1; exp_pulse = 1'b1; end
      else begin exp_line = cur_pol[n-32]; exp_pulse = 1'b0; end
    end else if (exp_pulse) begin
      exp_line = 1'b0; exp_pulse = 1'b0;
    end
  endtask

  task automatic step(input logic v, input int s, input int p, input string tag);
    @(negedge clk);
    evt_valid = v; evt_slot = 5'(s); evt_pin = 2'(p);
    edge_cfg = cur_edge; pol_cfg = cur_pol;
    model(v, s, p);
    @(posedge clk); #1;
    check(int'(cpu_irq), int'(exp_line), tag);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    string tag;
    repeat (3) @(posedge clk);
    #1 check(int'(cpu_irq), 0, "R5 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check(int'(cpu_irq), 0, "R5 after reset");

    // Exhaustive mapping sweep, no strobe
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk); evt_slot = 5'(s); evt_pin = 2'(p); #1;
        if (s == 5) tag = "R1 map";
        else if (s == 6 || s == 7) tag = "R2 map";
        else if (s >= 8 && s <= 12) tag = "R3 map";
        else tag = "R4 map";
        check(int'(irq_num), exp_num(s, p), tag);
      end
    end
    @(posedge clk); #1 check(int'(cpu_irq), 0, "R11 idle after sweep");

    // Level high on slot 6 (local 4), then hold and config-only changes
    cur_edge = '0; cur_pol = 32'h0000_0010;
    step(1, 6, 2, "R7 level high");
    step(0, 0, 0, "R11 hold");
    cur_pol = '0; cur_edge = 32'hFFFF_FFFF;
    step(0, 6, 0, "R11 cfg change ignored");
    step(0, 9, 1, "R11 cfg change ignored");
    // Non-local event does not disturb a held level
    step(1, 0, 3, "R9 passthrough hold");
    step(1, 20, 1, "R9 passthrough hold");
    // Level low on slot 7 (local 5)
    cur_edge = '0; cur_pol = '0;
    step(1, 7, 0, "R8 level low");
    // Edge pulse on slot 8 pin 0 (local 6)
    cur_edge = 32'h0000_0040;
    step(1, 8, 0, "R6 pulse high");
    step(0, 8, 0, "R6 pulse end");
    step(0, 8, 0, "R6 stays low");
    // Back-to-back pulses
    step(1, 8, 0, "R10 pulse 1");
    step(1, 8, 0, "R10 pulse 2 overlaps end");
    step(0, 0, 0, "R6 end after pair");
    // Pulse followed by level events in the ending cycle
    cur_pol = 32'h0000_0080;             // local 7 = slot 9 pin 0 level high
    step(1, 8, 0, "R6 pulse");
    step(1, 9, 0, "R10 level high wins");
    step(0, 0, 0, "R11 level held");
    cur_pol = '0;
    step(1, 8, 0, "R6 pulse");
    step(1, 9, 0, "R10 level low wins");
    // Pulse followed by non-local event ends normally
    step(1, 8, 0, "R6 pulse");
    step(1, 2, 1, "R9 pulse ends on foreign");
    // Slot 5 pin 3 (local 3) and slot 12 pin 3 (local 13)
    cur_edge = '0; cur_pol = 32'h0000_2008;
    step(1, 5, 3, "R1 level high local3");
    step(1, 12, 3, "R3 level high local13");
    cur_pol = 32'h0000_0008;
    step(1, 12, 3, "R3 level low local13");

    // Pseudo-random mix against the model
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[31:28] == 4'h0) begin
        cur_edge = lfsr ^ 32'h5A5A_3C3C;
        cur_pol  = {lfsr[15:0], lfsr[31:16]};
      end
      step(lfsr[1:0] != 2'b00, int'(lfsr[7:4]) + (lfsr[8] ? 16 : 0) * int'(lfsr[9]),
           int'(lfsr[11:10]), "R6/R7/R8/R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule